// File: doc/BRIEF.md
# Capture/Compare Timer Channel

A single timer channel for a peripheral subsystem. A 16-bit up-counter advances on ticks that come from one of four sources (a neighbouring channel's tick, every system clock, one system clock in sixteen, or rising edges of an external input), thinned out by an 8-bit prescaler. When the count meets a programmable reference the channel raises a reference event. It can either return to zero or keep free-running, and it drives a reference output that pulses or toggles.

The same external input can also serve as a capture trigger. On the selected edge the present count is latched into a capture register and a capture event is raised. Both events sit in a two-bit event register that software clears by writing ones. An interrupt line combines the events with their enables. A small register bus with a single write strobe and a combinational read path reaches every register.

Top module: `cc_timer`

## Requirements
- R1: After a synchronous active-low reset every register reads 0, and `irq` and `ref_out` are low.
- R2: Register map by `bus_addr`: 0 control, 1 mode, 2 reference, 3 capture, 4 count, 5 events. Addresses 6 and 7 read 0. Mode bits 2:1 pick the tick source: 00 `casc_tick`, 01 every clock, 10 one clock in 16 (a free-running 4-bit divider pulses while it holds 15), 11 rising edge of the synchronised `ext_in`. The mode register reads back as written.
- R3: With mode bits 15:8 equal to N, the count advances once per N+1 source ticks.
- R4: At a tick where the count equals the reference, event bit 1 is set. If mode bit 3 is 1 the count returns to 0, otherwise it increments and wraps past 0xFFFF.
- R5: `ext_in` passes two synchronising flops. Mode bits 7:6 select capture: 00 off, 01 rising, 10 falling, 11 either edge. A capture copies the count into the capture register and sets event bit 0 on the same edge.
- R6: Writing the event register clears each bit written as 1 and keeps each bit written as 0. An event arriving on the same edge as its clear leaves the bit set.
- R7: `irq` = (event bit 1 AND mode bit 4) OR (event bit 0 AND mode bits 7:6 not 00).
- R8: With mode bit 5 at 0, `ref_out` is high for the one cycle after each reference match. With it at 1, `ref_out` toggles after each match.
- R9: While control bit 0 is 0, the count, prescaler and divider are held at 0, capture is off, and count writes have no effect.
- R10: While control bits are 11 (enabled and stopped), the count, prescaler and divider hold their values, but register writes, including a count write, still take effect.
- R11: With control bit 0 at 1, a count write loads the count and takes priority over a tick. The capture register ignores writes. Mode bit 0 is stored but has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the addressed register (combinational) |
| casc_tick | input | 1 | Tick from a neighbouring channel (source 00) |
| ext_in | input | 1 | Asynchronous external input for clocking and capture |
| irq | output | 1 | Interrupt request |
| ref_out | output | 1 | Reference output, pulse or toggle |

## Verification
Two collisions matter most. The first is an event-clear write landing on the edge where the same event fires again. The second is a count write landing on a tick, which can coincide with a reference match or a capture. A reference of 0 with an undivided clock makes the match fire on every edge. A clear written into that stream must leave event bit 1 set, and this is checked against a fixed expected value. Randomised traffic then mixes small references, small prescalers, toggling `ext_in` and random register writes. Every cycle it compares `irq`, `ref_out` and the addressed register with a cycle-level model kept in the bench.

// File: rtl/cct_pkg.sv
// Package: shared constants, register addresses and the mode register layout
// for the capture/compare timer channel.
package cct_pkg;
    localparam int REG_W  = 16;
    localparam int PSC_W  = 8;
    localparam int ADDR_W = 3;
    localparam int EV_W   = 2;

    localparam logic [ADDR_W-1:0] ADR_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_MODE = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_REF  = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_CAP  = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_CNT  = 3'd4;
    localparam logic [ADDR_W-1:0] ADR_EVT  = 3'd5;

    localparam int CTRL_RUN_BIT  = 0;
    localparam int CTRL_HALT_BIT = 1;

    typedef enum logic [1:0] {
        SRC_CASC  = 2'b00,
        SRC_SYS   = 2'b01,
        SRC_DIV16 = 2'b10,
        SRC_EXT   = 2'b11
    } clk_src_e;

    typedef enum logic [1:0] {
        CAP_OFF  = 2'b00,
        CAP_RISE = 2'b01,
        CAP_FALL = 2'b10,
        CAP_BOTH = 2'b11
    } cap_edge_e;

    // Mode register, most significant field first (bits 15:8 down to bit 0).
    typedef struct packed {
        logic [PSC_W-1:0] psc;
        cap_edge_e        cap_edge;
        logic             out_toggle;
        logic             ref_ie;
        logic             restart;
        clk_src_e         src;
        logic             gate;
    } mode_t;
endpackage

// File: rtl/cct_in_sync.sv
// Module: cct_in_sync
// Brings an asynchronous level into the clock domain through a chain of
// STAGES flops and reports single-cycle rising and falling edges of the
// synchronised level. Assumes STAGES >= 2.
module cct_in_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              last_q;

    // Stage 0 samples the raw input.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= 1'b0;
        else        chain[0] <= din;
    end

    genvar g;
    generate
        for (g = 1; g < STAGES; g++) begin : g_stage
            // Each further stage re-samples the previous one.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= 1'b0;
                else        chain[g] <= chain[g-1];
            end
        end
    endgenerate

    // Previous synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= chain[STAGES-1];
    end

    assign rise = chain[STAGES-1] & ~last_q;
    assign fall = ~chain[STAGES-1] & last_q;
endmodule

// File: rtl/cct_tick_gen.sv
// Module: cct_tick_gen
// Chooses the tick source, keeps the free-running divide-by-2^DIV_W enable
// and the prescaler, and emits one count-enable per psc+1 source ticks.
// Assumes en=0 means held in reset and run = en & ~stop.
module cct_tick_gen
    import cct_pkg::*;
#(
    parameter int P_W   = PSC_W,
    parameter int DIV_W = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en,
    input  logic           run,
    input  clk_src_e       src,
    input  logic           casc_tick,
    input  logic           ext_rise,
    input  logic [P_W-1:0] psc,
    output logic           tick
);
    localparam logic [DIV_W-1:0] DIV_LAST = {DIV_W{1'b1}};

    logic [DIV_W-1:0] div_q;
    logic [P_W-1:0]   pcnt_q;
    logic             src_tick;
    logic             psc_done;

    // Select which event counts as one source tick.
    always_comb begin
        unique case (src)
            SRC_CASC:  src_tick = casc_tick;
            SRC_SYS:   src_tick = 1'b1;
            SRC_DIV16: src_tick = (div_q == DIV_LAST);
            SRC_EXT:   src_tick = ext_rise;
            default:   src_tick = 1'b0;
        endcase
    end

    assign psc_done = (pcnt_q == psc);
    assign tick     = run & src_tick & psc_done;

    // Free-running divider, cleared while disabled, frozen while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) div_q <= '0;
        else if (run)      div_q <= div_q + 1'b1;
    end

    // Prescaler: counts source ticks and wraps after psc+1 of them.
    always_ff @(posedge clk) begin
        if (!rst_n || !en)        pcnt_q <= '0;
        else if (run && src_tick) pcnt_q <= psc_done ? '0 : pcnt_q + 1'b1;
    end
endmodule

// File: rtl/cct_core.sv
// Module: cct_core
// Holds the main counter, reference compare, capture register, event flags
// and the reference output. Assumes tick is already gated by enable and stop,
// and cap_hit is the edge selected by the mode register.
module cct_core #(
    parameter int CNT_W = 16,
    parameter int E_W   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic             restart,
    input  logic             out_toggle,
    input  logic [CNT_W-1:0] ref_val,
    input  logic             cnt_we,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             cap_hit,
    input  logic [E_W-1:0]   ev_clr,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cap,
    output logic [E_W-1:0]   ev,
    output logic             match,
    output logic             cap_ev,
    output logic             ref_out
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cap_q;
    logic [E_W-1:0]   ev_q;
    logic [E_W-1:0]   ev_set;
    logic             ro_q;

    assign match  = tick & (cnt_q == ref_val);
    assign cap_ev = en & cap_hit;
    assign ev_set = {match, cap_ev};

    // Counter: cleared while disabled, software load beats a tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !en)  cnt_q <= '0;
        else if (cnt_we)    cnt_q <= cnt_wdata;
        else if (tick)      cnt_q <= (match && restart) ? '0 : cnt_q + 1'b1;
    end

    // Capture register latches the count seen at the capture edge.
    always_ff @(posedge clk) begin
        if (!rst_n)      cap_q <= '0;
        else if (cap_ev) cap_q <= cnt_q;
    end

    // Event flags: write-one-to-clear, a new event wins over its clear.
    always_ff @(posedge clk) begin
        if (!rst_n) ev_q <= '0;
        else        ev_q <= (ev_q & ~ev_clr) | ev_set;
    end

    // Reference output: one-cycle pulse or toggle per match.
    always_ff @(posedge clk) begin
        if (!rst_n)          ro_q <= 1'b0;
        else if (out_toggle) ro_q <= ro_q ^ match;
        else                 ro_q <= match;
    end

    assign cnt     = cnt_q;
    assign cap     = cap_q;
    assign ev      = ev_q;
    assign ref_out = ro_q;
endmodule

// File: rtl/cc_timer.sv
// Module: cc_timer (top)
// One capture/compare timer channel: register file and bus decode, input
// synchroniser, tick generation and counter core, plus the interrupt
// combine. Assumes a single-cycle write strobe and combinational reads.
module cc_timer
    import cct_pkg::*;
#(
    parameter int DIV_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              casc_tick,
    input  logic              ext_in,
    output logic              irq,
    output logic              ref_out
);
    localparam int CNT_W = REG_W;

    logic [1:0]       ctrl_q;
    mode_t            mode_q;
    logic [CNT_W-1:0] ref_q;
    logic             en, halt, run;
    logic             ext_rise, ext_fall, cap_hit;
    logic             tick, match, cap_ev;
    logic             cnt_we;
    logic [EV_W-1:0]  ev_clr;
    logic [CNT_W-1:0] cnt, cap;
    logic [EV_W-1:0]  ev;

    // Writable configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            mode_q <= '0;
            ref_q  <= '0;
        end else if (bus_we) begin
            unique case (bus_addr)
                ADR_CTRL: ctrl_q <= bus_wdata[1:0];
                ADR_MODE: mode_q <= mode_t'(bus_wdata);
                ADR_REF:  ref_q  <= bus_wdata;
                default:  ;
            endcase
        end
    end

    assign en     = ctrl_q[CTRL_RUN_BIT];
    assign halt   = ctrl_q[CTRL_HALT_BIT];
    assign run    = en & ~halt;
    assign cnt_we = bus_we && (bus_addr == ADR_CNT);
    assign ev_clr = (bus_we && (bus_addr == ADR_EVT)) ? bus_wdata[EV_W-1:0] : '0;

    cct_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (ext_in),
        .rise (ext_rise),
        .fall (ext_fall)
    );

    // Pick the capture edge named by the mode register.
    always_comb begin
        unique case (mode_q.cap_edge)
            CAP_OFF:  cap_hit = 1'b0;
            CAP_RISE: cap_hit = ext_rise;
            CAP_FALL: cap_hit = ext_fall;
            CAP_BOTH: cap_hit = ext_rise | ext_fall;
            default:  cap_hit = 1'b0;
        endcase
    end

    cct_tick_gen #(.P_W(PSC_W), .DIV_W(DIV_W)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .run      (run),
        .src      (mode_q.src),
        .casc_tick(casc_tick),
        .ext_rise (ext_rise),
        .psc      (mode_q.psc),
        .tick     (tick)
    );

    cct_core #(.CNT_W(CNT_W), .E_W(EV_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .tick      (tick),
        .restart   (mode_q.restart),
        .out_toggle(mode_q.out_toggle),
        .ref_val   (ref_q),
        .cnt_we    (cnt_we),
        .cnt_wdata (bus_wdata),
        .cap_hit   (cap_hit),
        .ev_clr    (ev_clr),
        .cnt       (cnt),
        .cap       (cap),
        .ev        (ev),
        .match     (match),
        .cap_ev    (cap_ev),
        .ref_out   (ref_out)
    );

    assign irq = (ev[1] & mode_q.ref_ie) | (ev[0] & (mode_q.cap_edge != CAP_OFF));

    // Read mux over the register map.
    always_comb begin
        unique case (bus_addr)
            ADR_CTRL: bus_rdata = {{(REG_W-2){1'b0}}, ctrl_q};
            ADR_MODE: bus_rdata = mode_q;
            ADR_REF:  bus_rdata = ref_q;
            ADR_CAP:  bus_rdata = cap;
            ADR_CNT:  bus_rdata = cnt;
            ADR_EVT:  bus_rdata = {{(REG_W-EV_W){1'b0}}, ev};
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/cct_checker.sv
// Module: cct_checker
// Temporal properties of the timer channel, attached to cc_timer by bind.
module cct_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             halt,
    input logic             restart,
    input logic             cnt_we,
    input logic             ev_we,
    input logic [1:0]       ev_wdata,
    input logic             match,
    input logic             cap_ev,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] cap,
    input logic [1:0]       ev,
    input logic             irq
);
    p_restart_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (match && restart && !cnt_we) |=> (cnt == '0));

    p_capture_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cap_ev |=> (ev[0] && (cap == $past(cnt))));

    p_w1c_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_we && ev_wdata[1] && !match) |=> !ev[1]);

    p_no_irq_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == 2'b00) |-> !irq);

    p_held_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (cnt == '0));

    p_stop_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (en && halt && !cnt_we) |=> $stable(cnt));
endmodule

bind cc_timer cct_checker #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .halt    (halt),
    .restart (mode_q.restart),
    .cnt_we  (cnt_we),
    .ev_we   (bus_we && (bus_addr == ADR_EVT)),
    .ev_wdata(bus_wdata[1:0]),
    .match   (match),
    .cap_ev  (cap_ev),
    .cnt     (cnt),
    .cap     (cap),
    .ev      (ev),
    .irq     (irq)
);

// File: tb/sim_cc_timer.sv
// Bench for cc_timer: directed corner cases plus seeded random traffic,
// compared every cycle against a behavioural model kept here.
module sim_cc_timer;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        casc_tick = 1'b0;
    logic        ext_in = 1'b0;
    logic        irq, ref_out;

    int checks = 0;
    int errors = 0;

    always #(CLK_P/2) clk = ~clk;

    cc_timer u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .casc_tick(casc_tick),
        .ext_in(ext_in), .irq(irq), .ref_out(ref_out)
    );

    // ---------------- behavioural model ----------------
    logic [1:0]  m_ctrl;
    logic [15:0] m_mode, m_ref, m_cnt, m_cap;
    logic [7:0]  m_pcnt;
    logic [3:0]  m_div;
    logic [1:0]  m_ev, m_s, m_clr;
    logic        m_last, m_ro;
    logic        m_en, m_run, m_src, m_tk, m_mt, m_ce, m_rise, m_fall;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = 0; m_mode = 0; m_ref = 0; m_cnt = 0; m_cap = 0;
            m_pcnt = 0; m_div = 0; m_ev = 0; m_s = 0; m_last = 0; m_ro = 0;
        end else begin
            m_rise = m_s[1] & ~m_last;
            m_fall = ~m_s[1] & m_last;
            case (m_mode[2:1])
                2'b00:   m_src = casc_tick;
                2'b01:   m_src = 1'b1;
                2'b10:   m_src = (m_div == 4'hF);
                default: m_src = m_rise;
            endcase
            m_en  = m_ctrl[0];
            m_run = m_en & ~m_ctrl[1];
            m_tk  = m_run & m_src & (m_pcnt == m_mode[15:8]);
            m_mt  = m_tk & (m_cnt == m_ref);
            case (m_mode[7:6])
                2'b00:   m_ce = 1'b0;
                2'b01:   m_ce = m_rise;
                2'b10:   m_ce = m_fall;
                default: m_ce = m_rise | m_fall;
            endcase
            m_ce  = m_ce & m_en;
            m_clr = (bus_we && bus_addr == 3'd5) ? bus_wdata[1:0] : 2'b00;
            if (m_ce) m_cap = m_cnt;
            if (!m_en)                          m_cnt = 0;
            else if (bus_we && bus_addr == 3'd4) m_cnt = bus_wdata;
            else if (m_tk)                      m_cnt = (m_mt && m_mode[3]) ? 16'h0 : m_cnt + 16'h1;
            if (!m_en)                m_pcnt = 0;
            else if (m_run && m_src)  m_pcnt = (m_pcnt == m_mode[15:8]) ? 8'h0 : m_pcnt + 8'h1;
            if (!m_en)      m_div = 0;
            else if (m_run) m_div = m_div + 4'h1;
            m_ev   = (m_ev & ~m_clr) | {m_mt, m_ce};
            m_ro   = m_mode[5] ? (m_ro ^ m_mt) : m_mt;
            m_last = m_s[1];
            m_s    = {m_s[0], ext_in};
            if (bus_we) begin
                case (bus_addr)
                    3'd0:    m_ctrl = bus_wdata[1:0];
                    3'd1:    m_mode = bus_wdata;
                    3'd2:    m_ref  = bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [15:0] m_read(input logic [2:0] a);
        case (a)
            3'd0:    return {14'h0, m_ctrl};
            3'd1:    return m_mode;
            3'd2:    return m_ref;
            3'd3:    return m_cap;
            3'd4:    return m_cnt;
            3'd5:    return {14'h0, m_ev};
            default: return 16'h0;
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] a);
        case (a)
            3'd0:    return "R10 control";
            3'd1:    return "R2 mode";
            3'd2:    return "R4 reference";
            3'd3:    return "R5 capture";
            3'd4:    return "R3 count";
            3'd5:    return "R6 events";
            default: return "R2 unused address";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Compare all outputs with the model (called mid-cycle at the falling edge).
    task automatic do_checks();
        logic m_irq;
        m_irq = (m_ev[1] & m_mode[4]) | (m_ev[0] & (m_mode[7:6] != 2'b00));
        chk("R7 irq", {15'h0, irq}, {15'h0, m_irq});
        chk("R8 ref_out", {15'h0, ref_out}, {15'h0, m_ro});
        chk(tag_of(bus_addr), bus_rdata, m_read(bus_addr));
    endtask

    task automatic step(input logic we, input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        if (rst_n) do_checks();
        bus_we = we; bus_addr = a; bus_wdata = d;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 3'd4, 16'h0);
    endtask

    task automatic rd_expect(input logic [2:0] a, input logic [15:0] exp, input string tag);
        @(negedge clk);
        do_checks();
        bus_we = 1'b0; bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(CLK_P * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        for (int a = 0; a < 6; a++) rd_expect(3'(a), 16'h0, "R1 reset register");
        chk("R1 irq after reset", {15'h0, irq}, 16'h0);
        chk("R1 ref_out after reset", {15'h0, ref_out}, 16'h0);

        // R11: capture register ignores writes
        step(1'b1, 3'd3, 16'h1234);
        rd_expect(3'd3, 16'h0, "R11 capture write ignored");

        // R9: count write while disabled has no effect
        step(1'b1, 3'd4, 16'h0055);
        rd_expect(3'd4, 16'h0, "R9 count held while disabled");

        // R3/R4: system clock, restart, ref irq, reference 3
        step(1'b1, 3'd1, 16'h001A);
        step(1'b1, 3'd2, 16'h0003);
        step(1'b1, 3'd0, 16'h0001);
        idle(20);

        // R10: stop holds, count write still loads
        step(1'b1, 3'd0, 16'h0003);
        step(1'b1, 3'd4, 16'h0007);
        idle(5);
        rd_expect(3'd4, 16'h0007, "R10 count loaded and held while stopped");

        // R3 prescaler 2, R2 divide-by-16, toggle output
        step(1'b1, 3'd1, 16'h0234);
        step(1'b1, 3'd2, 16'h0001);
        step(1'b1, 3'd0, 16'h0001);
        idle(200);

        // R6: clear written on the same edge as a fresh reference match
        step(1'b1, 3'd0, 16'h0000);
        step(1'b1, 3'd1, 16'h000A);
        step(1'b1, 3'd2, 16'h0000);
        step(1'b1, 3'd0, 16'h0001);
        idle(3);
        step(1'b1, 3'd5, 16'h0002);
        rd_expect(3'd5, 16'h0002, "R6 set wins over clear");

        // R5: capture on rising edge, free-running
        step(1'b1, 3'd1, 16'h0052);
        step(1'b1, 3'd2, 16'hFFFF);
        step(1'b1, 3'd5, 16'h0003);
        idle(6);
        ext_in = 1'b1;
        idle(6);
        ext_in = 1'b0;
        idle(4);
        step(1'b1, 3'd5, 16'h0001);
        idle(3);

        // Random traffic
        for (int i = 0; i < 4000; i++) begin
            logic [2:0]  a;
            logic [15:0] d;
            logic        we;
            if ($urandom_range(0, 3) == 0) ext_in = ~ext_in;
            casc_tick = 1'($urandom_range(0, 1));
            a  = 3'($urandom_range(0, 7));
            we = ($urandom_range(0, 9) < 3);
            case (a)
                3'd0:    d = ($urandom_range(0, 4) == 0) ? 16'($urandom_range(0, 3)) : 16'h0001;
                3'd1:    d = {8'($urandom_range(0, 3)), 8'($urandom_range(0, 255))};
                3'd2:    d = 16'($urandom_range(0, 24));
                3'd4:    d = 16'($urandom_range(0, 30));
                default: d = 16'($urandom_range(0, 3));
            endcase
            step(we, a, d);
        end
        idle(2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule